// File: doc/BRIEF.md
# Repeating Serial Shift Sequencer

This block is a byte-addressed peripheral that shifts a programmable number of bits out of a local transmit buffer on a serial data line. It captures the same number of bits from a serial input into a receive buffer. A single launch runs the shift a programmable number of times, or without end, and inserts a programmable idle gap between runs. Software configures the block through a small register bank and reaches both data buffers in the same address space, above the registers.

The engine is a three-state machine. `ST_IDLE` waits for a launch. `ST_SHIFT` clocks one run of bits. `ST_GAP` counts idle cycles between runs. The transitions are: launch (`ST_IDLE` to `ST_SHIFT`), run-done-more (`ST_SHIFT` to `ST_GAP`, or straight back into `ST_SHIFT` when the gap is zero), gap-expired (`ST_GAP` to `ST_SHIFT`), sequence-done (`ST_SHIFT` to `ST_IDLE`) and abort (any state to `ST_IDLE` on a soft reset). A launch comes either from a bus write or from an on-chip trigger pulse, when the trigger gate is open.

Top module: `spi_seq_top`

## Requirements
- R1: After reset the block is idle. Byte 1 bit 0 (ready) reads 1, `sen_n` is 1, `sclk` is 0 and `mosi` is 0. Byte 0 reads 2 (version). Bytes 14 and 15 read the buffer size of 16 bytes, little-endian, and writes to them have no effect.
- R2: The registers are little-endian across consecutive byte addresses and read back what was written. The bit count (16 bits) sits at bytes 3 to 4, the gap length (32 bits) at bytes 5 to 8, the run count (32 bits) at bytes 9 to 12, and the trigger gate at bit 0 of byte 13. Bytes 2 and 48 to 63 read 0.
- R3: The transmit buffer occupies bytes 16 to 31 and is read and written by the bus. The receive buffer occupies bytes 32 to 47 and is read-only: bus writes to it are ignored.
- R4: A bus write of any value to byte 1 launches a sequence when the block is idle and the bit count is nonzero. Ready reads 0 from the next cycle on. A launch with a bit count of zero is ignored.
- R5: For each bit, `sclk` is low for one system clock and then high for one. While `sen_n` is low, `mosi` presents transmit bit k, taken MSB-first from byte 16 onward (bit k is bit 7-(k mod 8) of byte 16+k/8). It changes only when `sclk` falls. A run of N bits keeps `sen_n` low for 2N cycles.
- R6: `miso` is sampled on the clock edge at which `sclk` rises. Bit k is stored at bit 7-(k mod 8) of receive byte 32+k/8.
- R7: Between runs, `sen_n` is high for exactly the gap length in cycles. A gap of 0 runs back to back with `sen_n` held low.
- R8: A nonzero run count R gives exactly R runs and then ready. A run count of 0 repeats until a soft reset.
- R9: A one-cycle pulse on `ext_start` launches a sequence only when the trigger gate is 1.
- R10: Launch requests, from the bus or from the trigger, are ignored while a sequence is running.
- R11: A bus write to byte 0 aborts any sequence, so ready reads 1 and `sen_n` is 1 on the next cycle, and it leaves the registers unchanged. In the same cycle it wins over a trigger pulse.
- R12: A bit count above 128 is treated as 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_start | input | 1 | On-chip launch pulse, gated by the trigger gate |
| sclk | output | 1 | Serial clock, half the system clock rate |
| sen_n | output | 1 | Active-low serial enable, low during each run |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A soft reset and a launch request can fall in the same cycle. The bench provokes this in two ways. While the block is idle with the gate open, it drives a byte-0 write and an `ext_start` pulse on the same clock edge, and then expects ready to read 1 with `sen_n` high. During an endless sequence, it issues the reset in the middle of the shifting and expects ready on the next cycle, with the bit-count register still unchanged. The arithmetic sweeps count the busy cycles and the cycles with `sen_n` high, and compare them with R·2N+(R−1)·W.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_t;

    localparam logic [7:0] VERSION_ID = 8'd2;

    localparam int A_ABORT  = 0;
    localparam int A_LAUNCH = 1;
    localparam int A_NBITS  = 3;
    localparam int A_GAP    = 5;
    localparam int A_RUNS   = 9;
    localparam int A_GATE   = 13;
    localparam int A_BUFSZ  = 14;
    localparam int A_BUF    = 16;

endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
    import spi_seq_pkg::*;
#(
    parameter int MEM_BYTES = 16,
    parameter int ADDR_W    = 6,
    localparam int BITS     = MEM_BYTES * 8,
    localparam int IDX_W    = $clog2(BITS),
    localparam int BW       = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              ready,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic              cap_bit,
    output logic              soft_rst,
    output logic              start_wr,
    output logic [15:0]       cfg_nbits,
    output logic [31:0]       cfg_gap,
    output logic [31:0]       cfg_runs,
    output logic              cfg_gate,
    output logic [BITS-1:0]   tx_flat
);

    localparam int RX_BASE = A_BUF + MEM_BYTES;
    localparam int RX_END  = A_BUF + 2 * MEM_BYTES;

    logic [BITS-1:0]   tx_q, rx_q;
    logic [ADDR_W-1:0] toff, roff;
    logic              is_tx, is_rx;

    assign toff  = addr - ADDR_W'(A_BUF);
    assign roff  = addr - ADDR_W'(RX_BASE);
    assign is_tx = (int'(addr) >= A_BUF) && (int'(addr) < RX_BASE);
    assign is_rx = (int'(addr) >= RX_BASE) && (int'(addr) < RX_END);

    assign soft_rst = we && (int'(addr) == A_ABORT);
    assign start_wr = we && (int'(addr) == A_LAUNCH);
    assign tx_flat  = tx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_nbits <= '0;
            cfg_gap   <= '0;
            cfg_runs  <= '0;
            cfg_gate  <= 1'b0;
            tx_q      <= '0;
            rx_q      <= '0;
        end else begin
            if (we) begin
                for (int i = 0; i < 2; i++)
                    if (int'(addr) == A_NBITS + i) cfg_nbits[i*8 +: 8] <= wdata;
                for (int i = 0; i < 4; i++) begin
                    if (int'(addr) == A_GAP + i)  cfg_gap[i*8 +: 8]  <= wdata;
                    if (int'(addr) == A_RUNS + i) cfg_runs[i*8 +: 8] <= wdata;
                end
                if (int'(addr) == A_GATE) cfg_gate <= wdata[0];
                if (is_tx) tx_q[{toff[BW-1:0], 3'b000} +: 8] <= wdata;
            end
            if (cap_en) rx_q[{cap_idx[IDX_W-1:3], ~cap_idx[2:0]}] <= cap_bit;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (is_tx) begin
            rdata = tx_q[{toff[BW-1:0], 3'b000} +: 8];
        end else if (is_rx) begin
            rdata = rx_q[{roff[BW-1:0], 3'b000} +: 8];
        end else begin
            for (int i = 0; i < 2; i++)
                if (int'(addr) == A_NBITS + i) rdata = cfg_nbits[i*8 +: 8];
            for (int i = 0; i < 4; i++) begin
                if (int'(addr) == A_GAP + i)  rdata = cfg_gap[i*8 +: 8];
                if (int'(addr) == A_RUNS + i) rdata = cfg_runs[i*8 +: 8];
            end
            if (int'(addr) == A_ABORT)     rdata = VERSION_ID;
            if (int'(addr) == A_LAUNCH)    rdata = {7'd0, ready};
            if (int'(addr) == A_GATE)      rdata = {7'd0, cfg_gate};
            if (int'(addr) == A_BUFSZ)     rdata = 8'(MEM_BYTES);
            if (int'(addr) == A_BUFSZ + 1) rdata = 8'(MEM_BYTES >> 8);
        end
    end

    // R3: a bus write into the receive area leaves the receive buffer untouched
    p_rx_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && is_rx && !cap_en) |=> $stable(rx_q));

endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
    import spi_seq_pkg::*;
#(
    parameter int MEM_BYTES = 16,
    localparam int BITS     = MEM_BYTES * 8,
    localparam int IDX_W    = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             start_req,
    input  logic [15:0]      cfg_nbits,
    input  logic [31:0]      cfg_gap,
    input  logic [31:0]      cfg_runs,
    input  logic [BITS-1:0]  tx_flat,
    input  logic             miso,
    output logic             ready,
    output logic             sclk,
    output logic             sen_n,
    output logic             mosi,
    output logic             cap_en,
    output logic [IDX_W-1:0] cap_idx,
    output logic             cap_bit
);

    seq_state_t  state, state_nx;
    logic        ph;
    logic [15:0] bitc;
    logic [31:0] repc;
    logic [31:0] waitc;
    logic [15:0] eff_bits;
    logic        launch, last_bit, seq_done;

    assign eff_bits = (cfg_nbits > 16'(BITS)) ? 16'(BITS) : cfg_nbits;
    assign launch   = start_req && (eff_bits != 16'd0);
    assign last_bit = ph && (bitc == eff_bits - 16'd1);
    assign seq_done = (cfg_runs != 32'd0) && ((repc + 32'd1) >= cfg_runs);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (launch) state_nx = ST_SHIFT;
            ST_SHIFT: if (last_bit) begin
                          if (seq_done)                state_nx = ST_IDLE;
                          else if (cfg_gap == 32'd0)   state_nx = ST_SHIFT;
                          else                         state_nx = ST_GAP;
                      end
            ST_GAP:   if (waitc == 32'd0) state_nx = ST_SHIFT;
            default:  state_nx = ST_IDLE;
        endcase
        if (soft_rst) state_nx = ST_IDLE;
    end

    // bit, run and gap counters
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ph    <= 1'b0;
            bitc  <= '0;
            repc  <= '0;
            waitc <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    ph   <= 1'b0;
                    bitc <= '0;
                    repc <= '0;
                end
                ST_SHIFT: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (last_bit) begin
                            bitc  <= '0;
                            repc  <= repc + 32'd1;
                            waitc <= cfg_gap - 32'd1;
                        end else begin
                            bitc <= bitc + 16'd1;
                        end
                    end
                end
                ST_GAP:  waitc <= waitc - 32'd1;
                default: ph <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready   = (state == ST_IDLE);
        sen_n   = (state != ST_SHIFT);
        sclk    = (state == ST_SHIFT) && ph;
        mosi    = (state == ST_SHIFT) ? tx_flat[{bitc[IDX_W-1:3], ~bitc[2:0]}] : 1'b0;
        cap_en  = (state == ST_SHIFT) && !ph && !soft_rst;
        cap_idx = bitc[IDX_W-1:0];
        cap_bit = miso;
    end

    // R1: idle lines are quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (sen_n && !sclk && !mosi));

    // R5: serial clock toggles every cycle while shifting continues
    p_sclk_toggles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_SHIFT) |-> (sclk != $past(sclk)));

    // R11: abort reaches idle on the next cycle
    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ready);

    // R12: bit index never leaves the clamped window
    p_bit_window_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (bitc < eff_bits && int'(bitc) < BITS));

endmodule

// File: rtl/spi_seq_top.sv
module spi_seq_top
    import spi_seq_pkg::*;
#(
    parameter int MEM_BYTES = 16,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ext_start,
    output logic              sclk,
    output logic              sen_n,
    output logic              mosi,
    input  logic              miso
);

    localparam int BITS  = MEM_BYTES * 8;
    localparam int IDX_W = $clog2(BITS);

    logic             soft_rst, start_wr, cfg_gate, ready;
    logic [15:0]      cfg_nbits;
    logic [31:0]      cfg_gap, cfg_runs;
    logic [BITS-1:0]  tx_flat;
    logic             cap_en, cap_bit;
    logic [IDX_W-1:0] cap_idx;
    logic             start_req;

    assign start_req = start_wr || (ext_start && cfg_gate);

    spi_seq_regs #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .ready     (ready),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .cap_bit   (cap_bit),
        .soft_rst  (soft_rst),
        .start_wr  (start_wr),
        .cfg_nbits (cfg_nbits),
        .cfg_gap   (cfg_gap),
        .cfg_runs  (cfg_runs),
        .cfg_gate  (cfg_gate),
        .tx_flat   (tx_flat)
    );

    spi_seq_engine #(.MEM_BYTES(MEM_BYTES)) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .start_req (start_req),
        .cfg_nbits (cfg_nbits),
        .cfg_gap   (cfg_gap),
        .cfg_runs  (cfg_runs),
        .tx_flat   (tx_flat),
        .miso      (miso),
        .ready     (ready),
        .sclk      (sclk),
        .sen_n     (sen_n),
        .mosi      (mosi),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .cap_bit   (cap_bit)
    );

endmodule

// File: tb/spi_seq_top_tb_top.sv
module spi_seq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext_start = 1'b0;
    logic       miso = 1'b0;
    logic       sclk, sen_n, mosi;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int mon_n = 1;
    int seed = 0;
    int kcnt = 0;
    int frames = 0;
    int mosi_err = 0;
    logic [7:0] txb [16];

    always #10 clk = ~clk;

    spi_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .ext_start(ext_start),
        .sclk(sclk), .sen_n(sen_n), .mosi(mosi), .miso(miso)
    );

    function automatic logic pat(int k, int s);
        return ((k * 3 + s) % 5) < 2;
    endfunction

    function automatic logic exp_tx(int k);
        return txb[k / 8][7 - (k % 8)];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            checks++;
            finish_run();
        end
    end

    // serial slave model: drive miso while sclk low, check mosi while high
    always @(negedge clk) begin
        if (rst_n && !sen_n) begin
            if (!sclk) begin
                miso = pat(kcnt, seed);
            end else begin
                if (mosi !== exp_tx(kcnt)) mosi_err++;
                kcnt++;
                if (kcnt == mon_n) begin
                    kcnt = 0;
                    frames++;
                end
            end
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        we = 1'b1; addr = 6'(a); wdata = 8'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        addr = 6'(a);
        #1;
        d = int'(rdata);
    endtask

    task automatic cfg(int nbits, int gap, int runs);
        for (int i = 0; i < 2; i++) wr(3 + i, (nbits >> (8 * i)) & 255);
        for (int i = 0; i < 4; i++) wr(5 + i, (gap >> (8 * i)) & 255);
        for (int i = 0; i < 4; i++) wr(9 + i, (runs >> (8 * i)) & 255);
    endtask

    // launch by bus write, optionally retry launches while busy, then measure
    task automatic run(int nbits, int gap, int runs, int s, int retry_at);
        int eff, busy, gapc, d, bad;
        eff = (nbits > 128) ? 128 : nbits;
        for (int b = 0; b < 16; b++) begin
            txb[b] = 8'((b * 37 + s * 11 + 5) & 255);
            wr(16 + b, int'(txb[b]));
        end
        cfg(nbits, gap, runs);
        seed = s; mon_n = eff; kcnt = 0; frames = 0; mosi_err = 0;
        busy = 0; gapc = 0;
        wr(1, 8'h5a);
        forever begin
            we = (retry_at > 0 && busy == retry_at);
            ext_start = (retry_at > 0 && busy == retry_at + 2);
            rd(1, d);
            if (d[0]) break;
            busy++;
            if (sen_n) gapc++;
            @(negedge clk);
        end
        we = 1'b0; ext_start = 1'b0;
        chk(frames == runs, "R8 run count", frames, runs);
        chk(busy == runs * 2 * eff + (runs - 1) * gap, "R5 busy cycles", busy,
            runs * 2 * eff + (runs - 1) * gap);
        chk(gapc == (runs - 1) * gap, "R7 gap cycles", gapc, (runs - 1) * gap);
        chk(mosi_err == 0, "R5 mosi bits", mosi_err, 0);
        bad = 0;
        for (int k = 0; k < eff; k++) begin
            rd(32 + k / 8, d);
            if (d[7 - (k % 8)] != pat(k, s)) bad++;
        end
        chk(bad == 0, "R6 rx capture", bad, 0);
    endtask

    initial begin
        int d, busy, sizes[8], gaps[2];
        sizes = '{1, 3, 8, 9, 16, 127, 128, 200};
        gaps = '{0, 3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1
        chk(sen_n == 1 && sclk == 0 && mosi == 0, "R1 idle lines",
            {sen_n, sclk, mosi}, 3'b100);
        rd(0, d);  chk(d == 2, "R1 version", d, 2);
        rd(1, d);  chk(d == 1, "R1 ready", d, 1);
        rd(14, d); chk(d == 16, "R1 size lo", d, 16);
        rd(15, d); chk(d == 0, "R1 size hi", d, 0);
        wr(14, 99);
        rd(14, d); chk(d == 16, "R1 size read-only", d, 16);

        // R2
        cfg(16'h1234, 32'h89abcdef, 32'h01020304);
        wr(13, 8'hff);
        rd(3, d);  chk(d == 8'h34, "R2 nbits b0", d, 8'h34);
        rd(4, d);  chk(d == 8'h12, "R2 nbits b1", d, 8'h12);
        rd(5, d);  chk(d == 8'hef, "R2 gap b0", d, 8'hef);
        rd(8, d);  chk(d == 8'h89, "R2 gap b3", d, 8'h89);
        rd(9, d);  chk(d == 8'h04, "R2 runs b0", d, 8'h04);
        rd(12, d); chk(d == 8'h01, "R2 runs b3", d, 8'h01);
        rd(13, d); chk(d == 1, "R2 gate", d, 1);
        rd(2, d);  chk(d == 0, "R2 undefined 2", d, 0);
        rd(48, d); chk(d == 0, "R2 undefined 48", d, 0);
        rd(63, d); chk(d == 0, "R2 undefined 63", d, 0);
        wr(13, 0);

        // R3
        for (int b = 0; b < 16; b++) wr(16 + b, 255 - b * 7);
        for (int b = 0; b < 16; b++) begin
            rd(16 + b, d); chk(d == 255 - b * 7, "R3 tx readback", d, 255 - b * 7);
        end
        wr(40, 8'ha5);
        rd(40, d); chk(d == 0, "R3 rx write ignored", d, 0);

        // R4: zero length launch is ignored
        cfg(0, 0, 1);
        wr(1, 0);
        rd(1, d); chk(d == 1, "R4 zero length ignored", d, 1);

        // R5..R8, R12 sweep
        foreach (sizes[i])
            foreach (gaps[j])
                for (int r = 1; r <= 2; r++)
                    run(sizes[i], gaps[j], r, i * 4 + j * 2 + r, 0);

        // R10: relaunch via bus and trigger while busy
        wr(13, 1);
        run(16, 0, 1, 7, 6);
        run(10, 4, 2, 3, 25);

        // R9: trigger gate
        cfg(8, 0, 1);
        wr(13, 0);
        @(negedge clk); ext_start = 1'b1;
        @(negedge clk); ext_start = 1'b0;
        rd(1, d); chk(d == 1, "R9 gate closed", d, 1);
        wr(13, 1);
        @(negedge clk); ext_start = 1'b1;
        @(negedge clk); ext_start = 1'b0;
        rd(1, d); chk(d == 0, "R9 gate open", d, 0);
        repeat (20) @(negedge clk);
        rd(1, d); chk(d == 1, "R9 trigger run done", d, 1);

        // R11 + R8: endless runs aborted mid-shift
        cfg(4, 2, 0);
        seed = 1; mon_n = 4; kcnt = 0; frames = 0; mosi_err = 0;
        wr(1, 0);
        busy = 0;
        repeat (301) begin
            rd(1, d);
            if (d == 0) busy++;
            @(negedge clk);
        end
        chk(busy == 301, "R8 endless still busy", busy, 301);
        chk(frames >= 29, "R8 endless frame count", frames, 29);
        we = 1'b1; addr = 6'd0;
        @(negedge clk);
        we = 1'b0;
        rd(1, d); chk(d == 1, "R11 abort ready", d, 1);
        chk(sen_n == 1, "R11 abort sen_n", sen_n, 1);
        rd(3, d); chk(d == 4, "R11 config kept", d, 4);

        // R11: abort and trigger in the same cycle
        wr(13, 1);
        @(negedge clk);
        we = 1'b1; addr = 6'd0; ext_start = 1'b1;
        @(negedge clk);
        we = 1'b0; ext_start = 1'b0;
        rd(1, d); chk(d == 1, "R11 abort beats trigger", d, 1);
        chk(sen_n == 1, "R11 abort beats trigger sen_n", sen_n, 1);

        finish_run();
    end

endmodule